// File: doc/BRIEF.md
# Overcurrent Alarm Counter and Filter

This block watches an overcurrent alarm line that comes from outside the chip. A configuration bit selects whether the alarm is active high or active low. The line passes through a two-flop synchronizer. The block counts each transition from the inactive level to the active level as one event. When threshold checking is enabled and the count reaches a programmed value, a sticky interrupt is raised. The interrupt stays high until a clear input drops it, and the clear also restarts the count from zero.

A quiet-time filter, measured in clock cycles, empties the event counter when no new event has arrived for the programmed number of cycles. The filter then waits for the next event to arm it again. Programming the filter to zero turns this clearing off.

The block also drives a throttle request. The request is high while the synchronized alarm is active. After the alarm goes away, it stays high for a programmed number of microsecond ticks. A hold value of zero releases the request as soon as the alarm drops. Whatever acts on the throttle request is outside this block.

Top module: `oc_alarm_guard`

## Requirements
- R1: With `cfg_active_low`=1, a low level on `alarm_in` is the active level and a high level is idle. With `cfg_active_low`=0, high is active and low is idle.
- R2: One event is counted for each idle-to-active transition of the synchronized alarm. An alarm that is held active adds nothing more to `event_count`.
- R3: With `cfg_thresh_en`=1 and `cfg_thresh`=N (N>0), `irq` rises on the Nth event counted since reset or since the last clear, and not before.
- R4: With `cfg_thresh_en`=1 and `cfg_thresh`=0, the first event raises `irq`.
- R5: With `cfg_thresh_en`=0, `irq` never rises, whatever the number of events.
- R6: Once `irq` is high, it stays high until `irq_clear` is sampled high. That same edge drops `irq` and sets `event_count` to 0.
- R7: With `cfg_filter`=F>0, `event_count` becomes 0 at the Fth clock edge after the last event, provided no further event arrives in that time. Events spaced fewer than F cycles apart keep adding to the count.
- R8: With `cfg_filter`=0, `event_count` is never cleared by elapsed time.
- R9: `throttle_req` is high while the synchronized alarm is active. With `cfg_hold_us`=H>0, it stays high after the alarm drops until H rising-edge-sampled `us_tick` pulses have passed. Without ticks, it stays high indefinitely.
- R10: With `cfg_hold_us`=0, `throttle_req` falls in the same cycle that the synchronized alarm becomes idle.
- R11: A change on `alarm_in` reaches `throttle_req` after two clock edges. A new event shows in `event_count` after the third edge.
- R12: `event_count` saturates at its all-ones value, which is 255 for the default 8-bit width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alarm_in | input | 1 | Asynchronous overcurrent alarm line |
| cfg_active_low | input | 1 | 1: alarm active low; 0: active high |
| cfg_thresh_en | input | 1 | Enables the event-count interrupt |
| cfg_thresh | input | CNT_W | Event count at which the interrupt fires (0 = every event) |
| cfg_filter | input | FILT_W | Quiet cycles before the counter is cleared (0 = never) |
| cfg_hold_us | input | HOLD_W | Microsecond ticks that throttle is held after the alarm drops |
| us_tick | input | 1 | One-cycle pulse each microsecond |
| irq_clear | input | 1 | Clears the interrupt and the event count |
| irq | output | 1 | Sticky overcurrent interrupt |
| throttle_req | output | 1 | Throttle request |
| event_count | output | CNT_W | Current event count |

## Verification
The bench holds an alarm active for many cycles. A design that counts active cycles instead of transitions would show a large `event_count` where the correct value is 1. Threshold cases include the count one below N, exactly N, and threshold zero. A design that compares with the wrong operator fires one event early or late. The filter is sampled on both sides of its Fth edge, so an off-by-one timer shows a count of 1 at the wrong moment. A timer that ignores a filter of zero wipes the count during a long quiet stretch. The throttle hold is checked with no ticks, after H-1 ticks and after H ticks, which exposes a design that counts clock cycles or releases one tick early. Polarity is checked in both settings. Counter saturation is checked with 260 events, where a counter that wraps would read 4.

// File: rtl/oc_pkg.sv
package oc_pkg;

    // Synchronized alarm view: current level (active = 1) and a one-cycle
    // pulse on each idle-to-active transition.
    typedef struct packed {
        logic level;
        logic rise;
    } alarm_s;

    // Next state of the event counter and quiet timer.
    typedef struct packed {
        logic clr;   // counter returns to zero
        logic inc;   // counter increments
    } cnt_op_s;

endpackage

// File: rtl/oc_alarm_sync.sv
module oc_alarm_sync #(
    parameter int STAGES = 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           alarm_in,
    input  logic           active_low,
    output oc_pkg::alarm_s alarm
);
    logic [STAGES-1:0] chain;
    logic              lvl;
    logic              lvl_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain <= active_low;
                else     chain <= alarm_in;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) chain <= {STAGES{active_low}};
                else     chain <= {chain[STAGES-2:0], alarm_in};
            end
        end
    endgenerate

    assign lvl = chain[STAGES-1] ^ active_low;

    always_ff @(posedge clk) begin
        if (rst) lvl_q <= 1'b0;
        else     lvl_q <= lvl;
    end

    assign alarm.level = lvl;
    assign alarm.rise  = lvl & ~lvl_q;
endmodule

// File: rtl/oc_event_filter.sv
module oc_event_filter #(
    parameter int CNT_W  = 8,
    parameter int FILT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rise,
    input  logic              irq_clear,
    input  logic              thresh_en,
    input  logic [CNT_W-1:0]  thresh,
    input  logic [FILT_W-1:0] filter,
    output logic [CNT_W-1:0]  count,
    output logic              irq
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [FILT_W-1:0] quiet, quiet_n;
    logic [CNT_W-1:0]  base, cnt_n;
    logic              irq_n;
    logic              expire;
    oc_pkg::cnt_op_s   op;

    always_comb begin
        base   = irq_clear ? '0 : count;
        expire = (filter != '0) && (base != '0) && (quiet == filter - 1'b1);
        op.inc = rise;
        op.clr = !rise && expire;

        cnt_n   = base;
        quiet_n = quiet;
        if (irq_clear) quiet_n = '0;
        if (op.inc) begin
            cnt_n   = (base == CNT_MAX) ? CNT_MAX : base + 1'b1;
            quiet_n = '0;
        end else if (op.clr) begin
            cnt_n   = '0;
            quiet_n = '0;
        end else if (base != '0 && filter != '0) begin
            quiet_n = quiet + 1'b1;
        end

        irq_n = (irq && !irq_clear) || (op.inc && thresh_en && (cnt_n >= thresh));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
            quiet <= '0;
            irq   <= 1'b0;
        end else begin
            count <= cnt_n;
            quiet <= quiet_n;
            irq   <= irq_n;
        end
    end
endmodule

// File: rtl/oc_throttle_hold.sv
module oc_throttle_hold #(
    parameter int HOLD_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              active,
    input  logic              us_tick,
    input  logic [HOLD_W-1:0] hold_us,
    output logic              throttle
);
    logic [HOLD_W-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst)                          remain <= '0;
        else if (active)                  remain <= hold_us;
        else if (us_tick && remain != '0) remain <= remain - 1'b1;
    end

    assign throttle = active || (remain != '0);
endmodule

// File: rtl/oc_alarm_guard.sv
module oc_alarm_guard #(
    parameter int CNT_W       = 8,
    parameter int FILT_W      = 16,
    parameter int HOLD_W      = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              alarm_in,
    input  logic              cfg_active_low,
    input  logic              cfg_thresh_en,
    input  logic [CNT_W-1:0]  cfg_thresh,
    input  logic [FILT_W-1:0] cfg_filter,
    input  logic [HOLD_W-1:0] cfg_hold_us,
    input  logic              us_tick,
    input  logic              irq_clear,
    output logic              irq,
    output logic              throttle_req,
    output logic [CNT_W-1:0]  event_count
);
    oc_pkg::alarm_s alarm;

    oc_alarm_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst        (rst),
        .alarm_in   (alarm_in),
        .active_low (cfg_active_low),
        .alarm      (alarm)
    );

    oc_event_filter #(.CNT_W(CNT_W), .FILT_W(FILT_W)) u_filt (
        .clk       (clk),
        .rst       (rst),
        .rise      (alarm.rise),
        .irq_clear (irq_clear),
        .thresh_en (cfg_thresh_en),
        .thresh    (cfg_thresh),
        .filter    (cfg_filter),
        .count     (event_count),
        .irq       (irq)
    );

    oc_throttle_hold #(.HOLD_W(HOLD_W)) u_hold (
        .clk      (clk),
        .rst      (rst),
        .active   (alarm.level),
        .us_tick  (us_tick),
        .hold_us  (cfg_hold_us),
        .throttle (throttle_req)
    );
endmodule

// File: rtl/oc_alarm_guard_chk.sv
module oc_alarm_guard_chk #(
    parameter int CNT_W  = 8,
    parameter int FILT_W = 16,
    parameter int HOLD_W = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              cfg_thresh_en,
    input logic [FILT_W-1:0] cfg_filter,
    input logic [HOLD_W-1:0] cfg_hold_us,
    input logic              us_tick,
    input logic              irq_clear,
    input logic              irq,
    input logic              throttle_req,
    input logic [CNT_W-1:0]  event_count
);
    localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

    assert_irq_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        (irq && !irq_clear) |=> irq);

    assert_clear_count_R6: assert property (@(posedge clk) disable iff (rst)
        irq_clear |=> (!irq || event_count <= 1) && (event_count <= 1));

    assert_no_irq_disabled_R5: assert property (@(posedge clk) disable iff (rst)
        (!cfg_thresh_en && !irq) |=> !irq);

    assert_count_step_R2: assert property (@(posedge clk) disable iff (rst)
        !irq_clear |=> ({1'b0, event_count} <= {1'b0, $past(event_count)} + 1'b1));

    assert_no_time_clear_R8: assert property (@(posedge clk) disable iff (rst)
        (cfg_filter == '0 && !irq_clear && event_count != '0) |=> event_count != '0);

    assert_saturate_R12: assert property (@(posedge clk) disable iff (rst)
        (cfg_filter == '0 && !irq_clear && event_count == CMAX) |=> event_count == CMAX);

    assert_hold_no_tick_R9: assert property (@(posedge clk) disable iff (rst)
        (cfg_hold_us != '0 && throttle_req && !us_tick) |=> throttle_req);
endmodule

bind oc_alarm_guard oc_alarm_guard_chk #(.CNT_W(CNT_W), .FILT_W(FILT_W), .HOLD_W(HOLD_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .cfg_thresh_en (cfg_thresh_en),
    .cfg_filter    (cfg_filter),
    .cfg_hold_us   (cfg_hold_us),
    .us_tick       (us_tick),
    .irq_clear     (irq_clear),
    .irq           (irq),
    .throttle_req  (throttle_req),
    .event_count   (event_count)
);

// File: tb/tb_oc_alarm_guard.sv
module tb_oc_alarm_guard;
    logic        clk = 1'b0;
    logic        rst;
    logic        alarm_in;
    logic        cfg_active_low;
    logic        cfg_thresh_en;
    logic [7:0]  cfg_thresh;
    logic [15:0] cfg_filter;
    logic [11:0] cfg_hold_us;
    logic        us_tick;
    logic        irq_clear;
    logic        irq;
    logic        throttle_req;
    logic [7:0]  event_count;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    oc_alarm_guard dut (
        .clk(clk), .rst(rst), .alarm_in(alarm_in),
        .cfg_active_low(cfg_active_low), .cfg_thresh_en(cfg_thresh_en),
        .cfg_thresh(cfg_thresh), .cfg_filter(cfg_filter),
        .cfg_hold_us(cfg_hold_us), .us_tick(us_tick), .irq_clear(irq_clear),
        .irq(irq), .throttle_req(throttle_req), .event_count(event_count)
    );

    typedef struct packed {
        logic        al;
        logic        ten;
        logic [7:0]  th;
        logic [15:0] filt;
        logic [7:0]  np;
        logic [7:0]  cnt;
        logic        irq;
    } vec_t;

    // Each pulse: 3 cycles active, 4 idle; check 4 cycles after the last.
    localparam vec_t VECS [0:7] = '{
        '{1'b0, 1'b1, 8'd3, 16'd0,  8'd2, 8'd2, 1'b0},  // R3 one below N
        '{1'b0, 1'b1, 8'd3, 16'd0,  8'd3, 8'd3, 1'b1},  // R3 exactly N
        '{1'b1, 1'b1, 8'd3, 16'd0,  8'd3, 8'd3, 1'b1},  // R1 active low
        '{1'b0, 1'b1, 8'd0, 16'd0,  8'd1, 8'd1, 1'b1},  // R4 threshold 0
        '{1'b0, 1'b0, 8'd0, 16'd0,  8'd4, 8'd4, 1'b0},  // R5 disabled
        '{1'b0, 1'b1, 8'd2, 16'd5,  8'd3, 8'd0, 1'b0},  // R7 filter clears between events
        '{1'b0, 1'b1, 8'd3, 16'd10, 8'd3, 8'd3, 1'b1},  // R7 events within window accumulate
        '{1'b1, 1'b0, 8'd1, 16'd0,  8'd2, 8'd2, 1'b0}   // R5 with active low
    };

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        alarm_in  = cfg_active_low;
        us_tick   = 1'b0;
        irq_clear = 1'b0;
        rst       = 1'b1;
        cyc(3);
        rst = 1'b0;
        cyc(1);
    endtask

    task automatic pulse(int hi, int lo);
        alarm_in = ~cfg_active_low;
        cyc(hi);
        alarm_in = cfg_active_low;
        cyc(lo);
    endtask

    task automatic tick();
        us_tick = 1'b1;
        cyc(1);
        us_tick = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        cfg_active_low = 1'b0;
        cfg_thresh_en  = 1'b0;
        cfg_thresh     = '0;
        cfg_filter     = '0;
        cfg_hold_us    = '0;
        @(negedge clk);

        // Table walk
        for (int i = 0; i < 8; i++) begin
            cfg_active_low = VECS[i].al;
            cfg_thresh_en  = VECS[i].ten;
            cfg_thresh     = VECS[i].th;
            cfg_filter     = VECS[i].filt;
            cfg_hold_us    = '0;
            do_reset();
            for (int p = 0; p < int'(VECS[i].np); p++) pulse(3, 4);
            cyc(4);
            check($sformatf("R3/R4/R5/R7 vec%0d count", i), event_count, VECS[i].cnt);
            check($sformatf("R3/R4/R5/R7 vec%0d irq", i), irq, VECS[i].irq);
        end

        // Reset state, active high
        cfg_active_low = 1'b0; cfg_thresh_en = 1'b1; cfg_thresh = 8'd1;
        cfg_filter = '0; cfg_hold_us = '0;
        do_reset();
        check("reset irq", irq, 0);
        check("reset count", event_count, 0);
        check("R1 idle low no throttle", throttle_req, 0);

        // R11 latency, R1 active low, R2 held alarm, R10 zero hold
        cfg_active_low = 1'b1;
        do_reset();
        check("R1 idle high no throttle", throttle_req, 0);
        alarm_in = 1'b0;
        cyc(1);
        check("R11 throttle after one edge", throttle_req, 0);
        cyc(1);
        check("R11 throttle after two edges", throttle_req, 1);
        check("R11 count after two edges", event_count, 0);
        cyc(1);
        check("R11 count after three edges", event_count, 1);
        cyc(30);
        check("R2 held alarm counted once", event_count, 1);
        alarm_in = 1'b1;
        cyc(1);
        check("R10 throttle before sync", throttle_req, 1);
        cyc(1);
        check("R10 zero hold releases at once", throttle_req, 0);

        // R9 hold period in ticks
        cfg_active_low = 1'b0; cfg_hold_us = 12'd3;
        do_reset();
        alarm_in = 1'b1;
        cyc(3);
        alarm_in = 1'b0;
        cyc(2);
        check("R9 held after alarm drops", throttle_req, 1);
        cyc(10);
        check("R9 held without ticks", throttle_req, 1);
        tick(); tick();
        check("R9 held after H-1 ticks", throttle_req, 1);
        tick();
        check("R9 released after H ticks", throttle_req, 0);

        // R6 sticky interrupt and clear
        cfg_hold_us = '0; cfg_thresh_en = 1'b1; cfg_thresh = 8'd2; cfg_filter = '0;
        do_reset();
        pulse(3, 4); pulse(3, 4);
        check("R6 irq set", irq, 1);
        cyc(20);
        check("R6 irq sticky", irq, 1);
        irq_clear = 1'b1;
        cyc(1);
        irq_clear = 1'b0;
        check("R6 irq cleared", irq, 0);
        check("R6 count cleared", event_count, 0);
        pulse(3, 4);
        check("R6 restart count one", event_count, 1);
        check("R6 no irq after one restart event", irq, 0);
        pulse(3, 4);
        check("R6 irq after restart N", irq, 1);

        // R7 filter boundary, F=6
        cfg_filter = 16'd6; cfg_thresh_en = 1'b0;
        do_reset();
        alarm_in = 1'b1;
        cyc(1);
        alarm_in = 1'b0;
        cyc(7);
        check("R7 count before F-th edge", event_count, 1);
        cyc(1);
        check("R7 count at F-th edge", event_count, 0);

        // R8 filter zero never clears
        cfg_filter = '0;
        do_reset();
        pulse(1, 2);
        cyc(300);
        check("R8 count kept", event_count, 1);

        // R12 saturation
        do_reset();
        for (int p = 0; p < 260; p++) pulse(1, 2);
        cyc(4);
        check("R12 saturated count", event_count, 255);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule